// File: doc/BRIEF.md
# Dual-Role SPI Controller

This block is a full-duplex synchronous serial controller. It acts either as the bus master, generating the serial clock from a programmable divider, or as a slave clocked by a remote master. Bytes are 8 bits, shifted most significant bit first. Any of the four clock polarity and phase combinations can be chosen. Data to send enters a two-entry transmit queue, and received bytes collect in a two-entry receive queue.

The slave-select pin has four configurations. It can be ignored (3-wire). It can be an input, which selects the block when it is a slave and signals a competing master when it is a master. It can also be an output that follows a configuration bit, for use as a chip select.

When the select pin is an input and another master pulls it low while this block is master, a mode fault occurs: the master-enable bit clears, a sticky fault flag sets, and the clock and data outputs are released. As a slave, a programmable idle timeout flags a receive queue that holds data nobody is collecting.

The control state machine has three states:
- `ST_IDLE`: waiting.
- `ST_MXFER`: a master byte is in progress.
- `ST_SXFER`: selected as a slave.

Its transitions are:
- `ST_IDLE`→`ST_MXFER` when master is enabled, the transmit queue is not empty and the receive queue is not full.
- `ST_MXFER`→`ST_IDLE` at the end of the byte, on a mode fault, or when master is cleared.
- `ST_IDLE`→`ST_SXFER` when master is disabled and the block is selected.
- `ST_SXFER`→`ST_IDLE` on deselection or when master is enabled.

Top module: `spi_ctrl`

## Requirements
- R1: As master, a byte pushed into the transmit queue is shifted out MSB first on `mosi_o`, and the 8 bits sampled from `miso_i` land in the receive queue. With `miso_i` looped back to `mosi_o`, the received byte equals the sent byte in all four modes (`cfg_cpol`, `cfg_cpha`).
- R2: As master, each SCK half period lasts `cfg_div`+1 clock cycles, so the SCK frequency is clk/(2×(`cfg_div`+1)). A byte produces exactly 8 leading edges, and SCK rests at `cfg_cpol` when idle.
- R3: Each queue holds two bytes and delivers them in order. A push into a full queue is ignored. A slave with an empty transmit queue sends 0x00. `tx_full` is high when two bytes are waiting.
- R4: A master byte does not start while the receive queue is full. It starts once a byte is popped.
- R5: As slave with `cfg_nss_mode`=1 and `nss_i` low, the block receives `mosi_i` bytes and returns its transmit bytes on `miso_o`, back to back within one selection, in all four modes.
- R6: As slave with `cfg_nss_mode`=1, raising `nss_i` mid-byte discards the partial byte. The next selection starts at bit 7.
- R7: With `cfg_nss_mode`=0 or 3 (3-wire), a slave is always selected and `nss_i` is ignored.
- R8: As master with `cfg_nss_mode`=1, `nss_i` low causes a mode fault: `mode_fault` sets, `mstr_en` clears, `sck_oe` and `mosi_oe` drop, and the byte in progress is abandoned. `mf_clr` clears the flag.
- R9: With `cfg_nss_mode`=2, `nss_oe` is 1 and `nss_o` follows `cfg_cs_level`. In every other mode, `nss_oe` is 0.
- R10: As slave, with a non-zero `cfg_tmo`, `rx_tmo` rises once the receive queue has held data for `cfg_tmo` cycles with no SCK edge, push or pop. It falls when the queue is emptied. `cfg_tmo`=0 disables it.
- R11: `mstr_set` sets `mstr_en` and `mstr_clr` clears it. A fault clears it with priority over a set.
- R12: `sck_oe` and `mosi_oe` equal `mstr_en`. `miso_oe` is high only while the block is a selected slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| mstr_set | input | 1 | Pulse: enable master role |
| mstr_clr | input | 1 | Pulse: disable master role |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on leading edge, 1: sample on trailing edge |
| cfg_nss_mode | input | 2 | 0/3: 3-wire, 1: select/fault input, 2: chip-select output |
| cfg_cs_level | input | 1 | Level driven on nss_o in mode 2 |
| cfg_div | input | DIVW | SCK half-period minus one, in clock cycles |
| cfg_tmo | input | TMOW | Slave receive timeout in cycles, 0 disables |
| tx_data | input | DW | Byte to queue |
| tx_push | input | 1 | Push tx_data |
| tx_full | output | 1 | Transmit queue full |
| rx_data | output | DW | Oldest received byte |
| rx_pop | input | 1 | Pop rx_data |
| rx_valid | output | 1 | Receive queue not empty |
| rx_tmo | output | 1 | Slave receive timeout flag |
| mstr_en | output | 1 | Master role enabled |
| mode_fault | output | 1 | Sticky mode-fault flag |
| mf_clr | input | 1 | Clear mode_fault |
| sck_i | input | 1 | SCK from the bus |
| sck_o | output | 1 | SCK driven as master |
| sck_oe | output | 1 | SCK output enable |
| mosi_i | input | 1 | Slave data in |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | MOSI output enable |
| miso_i | input | 1 | Master data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | MISO output enable |
| nss_i | input | 1 | Select pin in |
| nss_o | output | 1 | Select pin out |
| nss_oe | output | 1 | Select pin output enable |

## Verification
Some properties are checked on every cycle:
- A mode fault never leaves master enabled.
- SCK rests at its idle level between master bytes.
- No master byte starts while the receive queue is full.
- Full queues hold their contents against pushes, and empty queues stay empty when popped.
- Divider ticks are spaced by the divisor.

Only the bench's scenarios show the rest:
- Bit order and loopback data across all four clock modes.
- The exact number of active SCK cycles for each divisor.
- Slave byte framing across back-to-back bytes and aborted selections.
- The timeout window and the chip-select output levels.

// File: rtl/spi_pkg.sv
package spi_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MXFER,
        ST_SXFER
    } spi_state_e;

    localparam logic [1:0] NSS_THREE_WIRE = 2'd0;
    localparam logic [1:0] NSS_SEL_IN     = 2'd1;
    localparam logic [1:0] NSS_CS_OUT     = 2'd2;
endpackage

// File: rtl/spi_fifo.sv
module spi_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign empty   = (cnt == '0);
    assign full    = (cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      cnt <= cnt + 1'b1;
            else if (do_pop && !do_push) cnt <= cnt - 1'b1;
        end
    end

    // R3: a full queue ignores a push and keeps its head
    p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop |=> full && rdata == $past(rdata));

    // R3: popping an empty queue changes nothing
    p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        empty && pop && !push |=> empty);
endmodule

// File: rtl/spi_sckgen.sv
module spi_sckgen #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW-1:0] cnt;

    assign tick = run && (cnt == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    // R2: with a non-zero divisor, two ticks are never adjacent
    p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick && div != '0 |=> !tick || div == '0);
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
    import spi_pkg::*;
#(
    parameter int DW     = 8,
    parameter int DIVW   = 8,
    parameter int TMOW   = 8,
    parameter int FDEPTH = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mstr_set,
    input  logic            mstr_clr,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic [1:0]      cfg_nss_mode,
    input  logic            cfg_cs_level,
    input  logic [DIVW-1:0] cfg_div,
    input  logic [TMOW-1:0] cfg_tmo,
    input  logic [DW-1:0]   tx_data,
    input  logic            tx_push,
    output logic            tx_full,
    output logic [DW-1:0]   rx_data,
    input  logic            rx_pop,
    output logic            rx_valid,
    output logic            rx_tmo,
    output logic            mstr_en,
    output logic            mode_fault,
    input  logic            mf_clr,
    input  logic            sck_i,
    output logic            sck_o,
    output logic            sck_oe,
    input  logic            mosi_i,
    output logic            mosi_o,
    output logic            mosi_oe,
    input  logic            miso_i,
    output logic            miso_o,
    output logic            miso_oe,
    input  logic            nss_i,
    output logic            nss_o,
    output logic            nss_oe
);
    localparam int BCW = $clog2(DW);

    spi_state_e      st, st_nx;
    logic            sck_s1, sck_s2, sck_s3, mosi_s1, mosi_s2, nss_s1, nss_s2;
    logic            tick, sck_r, fault_now, selected, load;
    logic            m_lead, m_trail, lead, trail, din, byte_end;
    logic [BCW:0]    hc;
    logic [BCW-1:0]  tcnt;
    logic [DW-1:0]   txs, rxs, tx_head, next_tx, rx_word;
    logic            tx_empty, tx_pop, rx_full, rx_empty;
    logic [TMOW-1:0] tmo_cnt;

    // Queues
    spi_fifo #(.W(DW), .DEPTH(FDEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data), .pop(tx_pop),
        .rdata(tx_head), .empty(tx_empty), .full(tx_full));

    spi_fifo #(.W(DW), .DEPTH(FDEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(byte_end), .wdata(rx_word), .pop(rx_pop),
        .rdata(rx_data), .empty(rx_empty), .full(rx_full));

    spi_sckgen #(.DIVW(DIVW)) u_sck (
        .clk(clk), .rst_n(rst_n), .run(st == ST_MXFER), .div(cfg_div), .tick(tick));

    // Pin synchronisers for the slave role
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sck_s1, sck_s2, sck_s3} <= '0;
            {mosi_s1, mosi_s2}       <= '0;
            {nss_s1, nss_s2}         <= 2'b11;
        end else begin
            {sck_s1, sck_s2, sck_s3} <= {sck_i, sck_s1, sck_s2};
            {mosi_s1, mosi_s2}       <= {mosi_i, mosi_s1};
            {nss_s1, nss_s2}         <= {nss_i, nss_s1};
        end
    end

    assign fault_now = mstr_en && (cfg_nss_mode == NSS_SEL_IN) && !nss_s2;
    assign selected  = (cfg_nss_mode == NSS_SEL_IN) ? !nss_s2 : 1'b1;

    // Edge events: internal divider as master, synchronised SCK as slave
    assign m_lead   = (st == ST_MXFER) && tick && !hc[0];
    assign m_trail  = (st == ST_MXFER) && tick && hc[0];
    assign lead     = m_lead  || ((st == ST_SXFER) && (sck_s3 == cfg_cpol) && (sck_s2 != cfg_cpol));
    assign trail    = m_trail || ((st == ST_SXFER) && (sck_s3 != cfg_cpol) && (sck_s2 == cfg_cpol));
    assign din      = (st == ST_MXFER) ? miso_i : mosi_s2;
    assign byte_end = trail && (tcnt == BCW'(DW - 1));
    assign rx_word  = cfg_cpha ? {rxs[DW-2:0], din} : rxs;
    assign next_tx  = tx_empty ? '0 : tx_head;
    assign load     = (st == ST_IDLE) && (st_nx != ST_IDLE);
    assign tx_pop   = (load || ((st == ST_SXFER) && byte_end)) && !tx_empty;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // Next state
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (fault_now)                        st_nx = ST_IDLE;
                else if (mstr_en) begin
                    if (!tx_empty && !rx_full)        st_nx = ST_MXFER;
                end else if (selected)                st_nx = ST_SXFER;
            end
            ST_MXFER: begin
                if (fault_now || !mstr_en || byte_end) st_nx = ST_IDLE;
            end
            ST_SXFER: begin
                if (mstr_en || !selected)             st_nx = ST_IDLE;
            end
            default:                                  st_nx = ST_IDLE;
        endcase
    end

    // Shift datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txs        <= '0;
            rxs        <= '0;
            tcnt       <= '0;
            hc         <= '0;
            sck_r      <= 1'b0;
            mstr_en    <= 1'b0;
            mode_fault <= 1'b0;
            tmo_cnt    <= '0;
        end else begin
            if (load) begin
                txs  <= next_tx;
                tcnt <= '0;
                hc   <= '0;
            end else if (st != ST_IDLE) begin
                if (lead) begin
                    if (!cfg_cpha)         rxs <= {rxs[DW-2:0], din};
                    else if (tcnt != '0)   txs <= {txs[DW-2:0], 1'b0};
                end
                if (trail) begin
                    if (cfg_cpha) rxs <= {rxs[DW-2:0], din};
                    if (byte_end) begin
                        tcnt <= '0;
                        if (st == ST_SXFER) txs <= next_tx;
                    end else begin
                        tcnt <= tcnt + 1'b1;
                        if (!cfg_cpha) txs <= {txs[DW-2:0], 1'b0};
                    end
                end
                if (tick) hc <= hc + 1'b1;
            end

            if (st != ST_MXFER || load) sck_r <= cfg_cpol;
            else if (m_lead)            sck_r <= ~cfg_cpol;
            else if (m_trail)           sck_r <= cfg_cpol;

            if (fault_now)     mstr_en <= 1'b0;
            else if (mstr_clr) mstr_en <= 1'b0;
            else if (mstr_set) mstr_en <= 1'b1;

            if (fault_now)   mode_fault <= 1'b1;
            else if (mf_clr) mode_fault <= 1'b0;

            if (mstr_en || rx_empty || byte_end || rx_pop || lead || trail) tmo_cnt <= '0;
            else if (tmo_cnt != cfg_tmo)                                     tmo_cnt <= tmo_cnt + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        sck_o    = sck_r;
        sck_oe   = mstr_en;
        mosi_o   = txs[DW-1];
        mosi_oe  = mstr_en;
        miso_o   = txs[DW-1];
        miso_oe  = (st == ST_SXFER);
        nss_o    = cfg_cs_level;
        nss_oe   = (cfg_nss_mode == NSS_CS_OUT);
        rx_valid = !rx_empty;
        rx_tmo   = !mstr_en && !rx_empty && (cfg_tmo != '0) && (tmo_cnt == cfg_tmo);
    end

    // R8: a fault leaves master disabled and the pins released
    p_fault_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mode_fault) |-> !mstr_en && !sck_oe);

    // R2: SCK rests at its idle level between master bytes
    p_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && $past(st == ST_IDLE) && $past(mstr_en) && $stable(cfg_cpol)
        |-> sck_o == cfg_cpol);

    // R4: no master byte begins while received data has no room
    p_no_start_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_IDLE && rx_full |=> st != ST_MXFER);
endmodule

// File: tb/spi_ctrl_tb.sv
module spi_ctrl_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, mstr_set, mstr_clr, cfg_cpol, cfg_cpha, cfg_cs_level;
    logic [1:0] cfg_nss_mode;
    logic [7:0] cfg_div, cfg_tmo, tx_data, rx_data;
    logic       tx_push, tx_full, rx_pop, rx_valid, rx_tmo, mstr_en, mode_fault, mf_clr;
    logic       sck_i, sck_o, sck_oe, mosi_i, mosi_o, mosi_oe, miso_i, miso_o, miso_oe;
    logic       nss_i, nss_o, nss_oe, lb;

    assign miso_i = lb ? mosi_o : 1'b0;

    spi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mstr_set(mstr_set), .mstr_clr(mstr_clr),
        .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_nss_mode(cfg_nss_mode),
        .cfg_cs_level(cfg_cs_level), .cfg_div(cfg_div), .cfg_tmo(cfg_tmo),
        .tx_data(tx_data), .tx_push(tx_push), .tx_full(tx_full), .rx_data(rx_data),
        .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_tmo(rx_tmo), .mstr_en(mstr_en),
        .mode_fault(mode_fault), .mf_clr(mf_clr), .sck_i(sck_i), .sck_o(sck_o),
        .sck_oe(sck_oe), .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
        .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe), .nss_i(nss_i),
        .nss_o(nss_o), .nss_oe(nss_oe));

    int nchk = 0, nerr = 0;
    bit done = 0;
    int act, leads, cyc;
    logic prev;
    logic [7:0] b, d, s0, s1, s2;

    task automatic chk(input string req, input logic [31:0] a, input logic [31:0] e);
        nchk++;
        if (a !== e) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, a, e);
        end
    endtask

    task automatic tk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_tx(input logic [7:0] v);
        tx_data = v; tx_push = 1'b1; tk(1); tx_push = 1'b0;
    endtask

    task automatic pop_rx(output logic [7:0] v);
        v = rx_data; rx_pop = 1'b1; tk(1); rx_pop = 1'b0;
    endtask

    task automatic pulse_set(); mstr_set = 1'b1; tk(1); mstr_set = 1'b0; tk(1); endtask
    task automatic pulse_clr(); mstr_clr = 1'b1; tk(1); mstr_clr = 1'b0; tk(1); endtask

    // Remote master model driving the slave
    task automatic sxfer(input logic [7:0] m, input int nb, output logic [7:0] s);
        s = '0;
        for (int i = 7; i > 7 - nb; i--) begin
            if (!cfg_cpha) begin
                mosi_i = m[i]; tk(8); s[i] = miso_o; sck_i = ~cfg_cpol; tk(8); sck_i = cfg_cpol;
            end else begin
                sck_i = ~cfg_cpol; mosi_i = m[i]; tk(8); s[i] = miso_o; sck_i = cfg_cpol;
            end
            tk(8);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mstr_set = 0; mstr_clr = 0; cfg_cpol = 0; cfg_cpha = 0;
        cfg_nss_mode = 2'd1; cfg_cs_level = 0; cfg_div = 0; cfg_tmo = 0;
        tx_data = 0; tx_push = 0; rx_pop = 0; mf_clr = 0;
        sck_i = 0; mosi_i = 0; nss_i = 1; lb = 1;
        tk(5); rst_n = 1; tk(3);

        // Reset state
        chk("R11 reset mstr_en", mstr_en, 0);
        chk("R8 reset mode_fault", mode_fault, 0);
        chk("R3 reset rx_valid", rx_valid, 0);
        chk("R3 reset tx_full", tx_full, 0);
        chk("R12 reset sck_oe", sck_oe, 0);
        chk("R12 reset miso_oe deselected", miso_oe, 0);

        // R11 / R12 master enable
        pulse_set();
        chk("R11 set", mstr_en, 1);
        chk("R12 sck_oe", sck_oe, 1);
        chk("R12 mosi_oe", mosi_oe, 1);
        pulse_clr();
        chk("R11 clear", mstr_en, 0);
        chk("R12 mosi_oe off", mosi_oe, 0);
        pulse_set();

        // R1 / R2 master loopback sweep over modes and divisors
        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 3; k++) begin
                cfg_cpol = m[1]; cfg_cpha = m[0]; cfg_div = (k == 2) ? 8'd3 : 8'(k);
                tk(4);
                b = 8'h5A ^ 8'(m * 49 + k * 15);
                push_tx(b);
                act = 0; leads = 0; prev = cfg_cpol; cyc = 0;
                while (!rx_valid && cyc < 500) begin
                    tk(1); cyc++;
                    if (sck_o !== cfg_cpol) act++;
                    if (sck_o !== cfg_cpol && prev === cfg_cpol) leads++;
                    prev = sck_o;
                end
                chk("R1 loopback byte", rx_data, b);
                chk("R2 active SCK cycles", act, 8 * (int'(cfg_div) + 1));
                chk("R2 leading edges", leads, 8);
                chk("R2 idle level", sck_o, cfg_cpol);
                pop_rx(d);
            end
        end

        // R3 order through two-deep queues
        cfg_cpol = 0; cfg_cpha = 0; cfg_div = 1; tk(4);
        push_tx(8'h81); push_tx(8'h7E);
        tk(120);
        pop_rx(d); chk("R3 first byte", d, 8'h81);
        pop_rx(d); chk("R3 second byte", d, 8'h7E);

        // R4 stall while receive queue is full
        push_tx(8'h11); push_tx(8'h22);
        tk(120);
        chk("R4 rx queue full", rx_valid, 1);
        push_tx(8'h33);
        leads = 0; prev = sck_o;
        for (int i = 0; i < 80; i++) begin
            tk(1);
            if (sck_o !== prev) leads++;
            prev = sck_o;
        end
        chk("R4 no SCK while full", leads, 0);
        pop_rx(d); chk("R4 head kept", d, 8'h11);
        tk(80);
        pop_rx(d); chk("R4 second", d, 8'h22);
        pop_rx(d); chk("R4 resumed byte", d, 8'h33);

        // R8 mode fault mid-byte
        cfg_div = 3; tk(2);
        push_tx(8'hA7);
        tk(20);
        nss_i = 0; tk(6);
        chk("R8 fault flag", mode_fault, 1);
        chk("R8 master cleared", mstr_en, 0);
        chk("R8 sck released", sck_oe, 0);
        chk("R8 mosi released", mosi_oe, 0);
        nss_i = 1; tk(4);
        chk("R8 byte abandoned", rx_valid, 0);
        mf_clr = 1; tk(1); mf_clr = 0; tk(1);
        chk("R8 flag cleared", mode_fault, 0);

        // R5 / R3 slave, four-wire select, all modes
        lb = 0;
        for (int m = 0; m < 4; m++) begin
            cfg_cpol = m[1]; cfg_cpha = m[0]; sck_i = cfg_cpol; tk(4);
            push_tx(8'hC3 ^ 8'(m)); push_tx(8'h3A ^ 8'(m * 3));
            chk("R3 tx_full", tx_full, 1);
            push_tx(8'hEE);
            nss_i = 0; tk(4);
            chk("R12 miso_oe selected", miso_oe, 1);
            sxfer(8'h96 ^ 8'(m), 8, s0);
            sxfer(8'h4D ^ 8'(m * 5), 8, s1);
            sxfer(8'hF0, 8, s2);
            chk("R5 slave tx byte0", s0, 8'hC3 ^ 8'(m));
            chk("R5 slave tx byte1", s1, 8'h3A ^ 8'(m * 3));
            chk("R3 empty queue sends zero", s2, 8'h00);
            nss_i = 1; tk(4);
            chk("R12 miso_oe deselected", miso_oe, 0);
            pop_rx(d); chk("R5 slave rx byte0", d, 8'h96 ^ 8'(m));
            pop_rx(d); chk("R5 slave rx byte1", d, 8'h4D ^ 8'(m * 5));
            chk("R3 full rx ignores push", rx_valid, 0);
        end

        // R6 deselect aborts a partial byte
        cfg_cpol = 0; cfg_cpha = 0; sck_i = 0; tk(2);
        nss_i = 0; tk(4);
        sxfer(8'hFF, 4, s0);
        nss_i = 1; tk(6);
        chk("R6 partial discarded", rx_valid, 0);
        nss_i = 0; tk(4);
        sxfer(8'h96, 8, s0);
        nss_i = 1; tk(4);
        pop_rx(d); chk("R6 fresh byte", d, 8'h96);

        // R7 three-wire ignores nss_i, R10 timeout
        cfg_tmo = 20; cfg_nss_mode = 2'd0; nss_i = 1; tk(4);
        chk("R7 selected without nss", miso_oe, 1);
        sxfer(8'h3C, 8, s0);
        chk("R10 no early timeout", rx_tmo, 0);
        tk(30);
        chk("R10 timeout raised", rx_tmo, 1);
        pop_rx(d);
        chk("R7 three-wire byte", d, 8'h3C);
        chk("R10 cleared on empty", rx_tmo, 0);
        cfg_tmo = 0;
        sxfer(8'h71, 8, s0);
        tk(40);
        chk("R10 disabled by zero", rx_tmo, 0);
        pop_rx(d); chk("R7 second byte", d, 8'h71);
        cfg_nss_mode = 2'd3; nss_i = 1; tk(4);
        chk("R7 mode 3 is three-wire", miso_oe, 1);

        // R9 chip-select output
        cfg_nss_mode = 2'd2; cfg_cs_level = 0; tk(2);
        chk("R9 nss_oe", nss_oe, 1);
        chk("R9 nss_o low", nss_o, 0);
        cfg_cs_level = 1; tk(1);
        chk("R9 nss_o high", nss_o, 1);
        cfg_nss_mode = 2'd0; tk(1);
        chk("R9 nss_oe off", nss_oe, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule